// File: doc/BRIEF.md
# Time Slot Data Link Extractor

The extractor sits behind a receive framer and pulls a low-rate data link out of a framed serial TDM stream. Each frame carries 32 time slots of 8 bits. The framer gives one strobe per received bit and marks the first bit of each frame with a frame-sync pulse. The extractor keeps only the bits that pass three filters at once: the parity of the frame, the chosen time slot, and a per-bit enable mask inside that slot. Each kept bit goes to a downstream HDLC receiver as a data bit with a one-clock valid pulse.

The three selection settings come in on plain configuration inputs. The block takes a copy of them at the start of every frame. Changing the inputs part way through a frame therefore has no effect until the next frame begins. Frame parity comes from an internal frame count. Every frame-sync pulse clears this count, so the frame that opens with a sync is always even.

Top module: `tsdl_extract`

## Requirements
- R1: While `rst_ni` is low and after it is released, `dl_valid_o` stays low until a kept bit has been received.
- R2: Before the first `frame_sync_i` pulse (qualified by `bit_strobe_i`), no bit is kept and `dl_valid_o` stays low.
- R3: A cycle with `bit_strobe_i` and `frame_sync_i` both high carries bit position 0 (slot 0, first bit). Each later strobe carries the next position. After 256 positions the count wraps to a new frame. The sync frame is even, and parity toggles on every wrap.
- R4: Only bits in the slot whose number (0 to 31) equals `cfg_slot_i` are kept. Slot n covers positions 8n to 8n+7.
- R5: Mask bit k of `cfg_bit_en_i` enables the k-th bit received in the chosen slot. Bit 0 is the first bit sent.
- R6: `cfg_frame_sel_i` 2'b00 keeps bits in all frames, 2'b01 in odd frames only, and 2'b10 in even frames only. Code 2'b11 keeps nothing.
- R7: An all-zero `cfg_bit_en_i` keeps nothing.
- R8: For a kept bit, `dl_valid_o` is high for exactly the one clock after its strobe cycle, and `dl_data_o` equals that bit's `rx_data_i`.
- R9: The configuration is captured on the strobe of position 0, whether that position comes from a sync or from a wrap. It is held unchanged for the rest of that frame.
- R10: A sync in the middle of a frame restarts the position at 0 and the parity at even, and reloads the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 1 | Serial receive data bit |
| bit_strobe_i | input | 1 | A receive bit is present this cycle |
| frame_sync_i | input | 1 | This strobed bit is the first bit of a frame |
| cfg_frame_sel_i | input | 2 | Frame parity selection |
| cfg_slot_i | input | 5 | Time slot to tap |
| cfg_bit_en_i | input | 8 | Per-bit enable mask within the slot |
| dl_data_o | output | 1 | Extracted data bit |
| dl_valid_o | output | 1 | Extracted bit valid, one clock per kept bit |

## Verification
On every cycle, the assertions check the following:
- each valid pulse follows a strobe and carries that strobe's data bit;
- no pulse appears before lock, with a zero mask, with the unused frame code, or outside the captured slot;
- the captured configuration never moves except after a frame-start strobe.

The bench scenarios cover what needs a view across whole frames: the odd and even parity counts after a sync, the bit order inside a slot, a settings change in mid-frame taking effect only from the next frame, and a resync in mid-frame. A reference model in the bench predicts every kept bit, and the bench compares the design's output against it.

// File: rtl/tsdl_pkg.sv
package tsdl_pkg;
  typedef enum logic [1:0] {
    FSEL_ALL  = 2'b00,
    FSEL_ODD  = 2'b01,
    FSEL_EVEN = 2'b10,
    FSEL_OFF  = 2'b11
  } fsel_e;

  function automatic logic frame_ok(input fsel_e sel, input logic odd);
    case (sel)
      FSEL_ALL:  frame_ok = 1'b1;
      FSEL_ODD:  frame_ok = odd;
      FSEL_EVEN: frame_ok = ~odd;
      default:   frame_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tsdl_pos_cnt.sv
module tsdl_pos_cnt #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int POS_W = $clog2(SLOTS * BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             sync_i,
  output logic [POS_W-1:0] pos_o,
  output logic             odd_o,
  output logic             frame_start_o,
  output logic             locked_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(SLOTS * BITS - 1);

  logic [POS_W-1:0] pos_q;
  logic             odd_q, locked_q;
  logic             sync, wrap;

  assign sync = strobe_i & sync_i;
  assign wrap = strobe_i & ~sync_i & (pos_q == LAST);

  assign pos_o         = sync ? '0 : (wrap ? '0 : pos_q + 1'b1);
  assign odd_o         = sync ? 1'b0 : (wrap ? ~odd_q : odd_q);
  assign frame_start_o = sync | wrap;
  assign locked_o      = locked_q | sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= LAST;
      odd_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (strobe_i) begin
      pos_q    <= pos_o;
      odd_q    <= odd_o;
      locked_q <= locked_o;
    end
  end
endmodule

// File: rtl/tsdl_cfg_shadow.sv
module tsdl_cfg_shadow
  import tsdl_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int BITS   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        fsel_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BITS-1:0]   mask_i,
  output fsel_e             eff_fsel_o,
  output logic [SLOT_W-1:0] eff_slot_o,
  output logic [BITS-1:0]   eff_mask_o,
  output fsel_e             shd_fsel_o,
  output logic [SLOT_W-1:0] shd_slot_o,
  output logic [BITS-1:0]   shd_mask_o
);
  fsel_e             fsel_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BITS-1:0]   mask_q;

  // the frame-start bit itself already uses the new settings
  assign eff_fsel_o = load_i ? fsel_e'(fsel_i) : fsel_q;
  assign eff_slot_o = load_i ? slot_i : slot_q;
  assign eff_mask_o = load_i ? mask_i : mask_q;
  assign shd_fsel_o = fsel_q;
  assign shd_slot_o = slot_q;
  assign shd_mask_o = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= FSEL_OFF;
      slot_q <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      fsel_q <= fsel_e'(fsel_i);
      slot_q <= slot_i;
      mask_q <= mask_i;
    end
  end
endmodule

// File: rtl/tsdl_select.sv
module tsdl_select
  import tsdl_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int POS_W  = $clog2(SLOTS * BITS),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W  = $clog2(BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              locked_i,
  input  logic              odd_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              data_i,
  input  fsel_e             fsel_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BITS-1:0]   mask_i,
  output logic [SLOT_W-1:0] cur_slot_o,
  output logic              data_o,
  output logic              valid_o
);
  logic [BIT_W-1:0] bit_idx;
  logic             keep;

  assign cur_slot_o = SLOT_W'(pos_i / BITS);
  assign bit_idx    = BIT_W'(pos_i % BITS);
  assign keep = strobe_i & locked_i & (cur_slot_o == slot_i)
              & mask_i[bit_idx] & frame_ok(fsel_i, odd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= 1'b0;
    end else begin
      valid_o <= keep;
      if (keep) data_o <= data_i;
    end
  end
endmodule

// File: rtl/tsdl_extract.sv
module tsdl_extract
  import tsdl_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int POS_W  = $clog2(SLOTS * BITS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_data_i,
  input  logic              bit_strobe_i,
  input  logic              frame_sync_i,
  input  logic [1:0]        cfg_frame_sel_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [BITS-1:0]   cfg_bit_en_i,
  output logic              dl_data_o,
  output logic              dl_valid_o
);
  logic [POS_W-1:0]  cur_pos;
  logic              cur_odd, frame_start, locked;
  fsel_e             eff_fsel, shd_fsel;
  logic [SLOT_W-1:0] eff_slot, shd_slot, cur_slot;
  logic [BITS-1:0]   eff_mask, shd_mask;

  tsdl_pos_cnt #(.SLOTS(SLOTS), .BITS(BITS)) u_pos (
    .clk_i, .rst_ni,
    .strobe_i      (bit_strobe_i),
    .sync_i        (frame_sync_i),
    .pos_o         (cur_pos),
    .odd_o         (cur_odd),
    .frame_start_o (frame_start),
    .locked_o      (locked)
  );

  tsdl_cfg_shadow #(.SLOT_W(SLOT_W), .BITS(BITS)) u_cfg (
    .clk_i, .rst_ni,
    .load_i     (frame_start),
    .fsel_i     (cfg_frame_sel_i),
    .slot_i     (cfg_slot_i),
    .mask_i     (cfg_bit_en_i),
    .eff_fsel_o (eff_fsel),
    .eff_slot_o (eff_slot),
    .eff_mask_o (eff_mask),
    .shd_fsel_o (shd_fsel),
    .shd_slot_o (shd_slot),
    .shd_mask_o (shd_mask)
  );

  tsdl_select #(.SLOTS(SLOTS), .BITS(BITS)) u_sel (
    .clk_i, .rst_ni,
    .strobe_i   (bit_strobe_i),
    .locked_i   (locked),
    .odd_i      (cur_odd),
    .pos_i      (cur_pos),
    .data_i     (rx_data_i),
    .fsel_i     (eff_fsel),
    .slot_i     (eff_slot),
    .mask_i     (eff_mask),
    .cur_slot_o (cur_slot),
    .data_o     (dl_data_o),
    .valid_o    (dl_valid_o)
  );
endmodule

// File: rtl/tsdl_extract_chk.sv
module tsdl_extract_chk
  import tsdl_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int BITS   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_data_i,
  input logic              bit_strobe_i,
  input logic              dl_data_o,
  input logic              dl_valid_o,
  input logic              locked,
  input logic              frame_start,
  input fsel_e             eff_fsel,
  input logic [SLOT_W-1:0] eff_slot,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [BITS-1:0]   eff_mask,
  input fsel_e             shd_fsel,
  input logic [SLOT_W-1:0] shd_slot,
  input logic [BITS-1:0]   shd_mask
);
  // R8
  valid_follows_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_valid_o |-> $past(bit_strobe_i));
  // R8
  data_matches_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_valid_o |-> dl_data_o == $past(rx_data_i));
  // R2
  no_out_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_valid_o |-> $past(locked));
  // R7
  zero_mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_valid_o |-> $past(eff_mask) != '0);
  // R6
  off_code_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_valid_o |-> $past(eff_fsel) != FSEL_OFF);
  // R4
  slot_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_valid_o |-> $past(cur_slot) == $past(eff_slot));
  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_start) |-> $stable({shd_fsel, shd_slot, shd_mask}));
endmodule

bind tsdl_extract tsdl_extract_chk #(.SLOT_W(SLOT_W), .BITS(BITS)) u_chk (
  .clk_i, .rst_ni, .rx_data_i, .bit_strobe_i, .dl_data_o, .dl_valid_o,
  .locked, .frame_start, .eff_fsel, .eff_slot, .cur_slot, .eff_mask,
  .shd_fsel, .shd_slot, .shd_mask
);

// File: tb/sim_tsdl_extract.sv
`timescale 1ns/1ps
module sim_tsdl_extract;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rx_data = 1'b0, bit_strobe = 1'b0, frame_sync = 1'b0;
  logic [1:0] cfg_sel = 2'b11;
  logic [4:0] cfg_slot = '0;
  logic [7:0] cfg_mask = '0;
  logic       dl_data, dl_valid;

  int checks = 0, fails = 0, rx_count = 0;
  logic exp_q[$];

  // reference model state
  int m_pos = 255, m_slot = 0;
  bit m_odd = 0, m_lock = 0;
  logic [1:0] m_sel = 2'b11;
  logic [7:0] m_mask = '0;

  always #5 clk = ~clk;

  tsdl_extract u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .bit_strobe_i(bit_strobe),
    .frame_sync_i(frame_sync), .cfg_frame_sel_i(cfg_sel), .cfg_slot_i(cfg_slot),
    .cfg_bit_en_i(cfg_mask), .dl_data_o(dl_data), .dl_valid_o(dl_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic d, input logic s);
    bit bnd, fr_ok, keep;
    @(negedge clk);
    rx_data = d; bit_strobe = 1'b1; frame_sync = s;
    bnd = 0;
    if (s) begin m_pos = 0; m_odd = 0; m_lock = 1; bnd = 1; end
    else begin
      m_pos = (m_pos + 1) % 256;
      if (m_pos == 0) begin m_odd = ~m_odd; bnd = 1; end
    end
    if (bnd) begin m_sel = cfg_sel; m_slot = int'(cfg_slot); m_mask = cfg_mask; end
    case (m_sel)
      2'b00: fr_ok = 1;
      2'b01: fr_ok = m_odd;
      2'b10: fr_ok = !m_odd;
      default: fr_ok = 0;
    endcase
    keep = m_lock && (m_pos / 8 == m_slot) && m_mask[m_pos % 8] && fr_ok;
    if (keep) exp_q.push_back(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_strobe = 1'b0; frame_sync = 1'b0;
    end
  endtask

  task automatic run_bits(input int n, input bit sync_first, input int chg_at,
                          input logic [1:0] nsel, input logic [4:0] nslot,
                          input logic [7:0] nmask);
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) begin cfg_sel = nsel; cfg_slot = nslot; cfg_mask = nmask; end
      drive_bit(1'($urandom), sync_first && i == 0);
      if (i % 37 == 5) idle(1);
    end
    idle(1);
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic [4:0] sl, input logic [7:0] m);
    cfg_sel = s; cfg_slot = sl; cfg_mask = m;
  endtask

  task automatic drain(input string req, input int exp_count);
    idle(3);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(rx_count == exp_count, req, rx_count, exp_count);
    rx_count = 0;
  endtask

  // monitor: compare each output bit against the scoreboard
  always @(negedge clk) begin
    if (rst_n && dl_valid) begin
      rx_count++;
      if (exp_q.size() == 0) check(0, "R8 unexpected valid", 1, 0);
      else begin
        logic e;
        e = exp_q.pop_front();
        check(dl_data == e, "R8/R5 data", int'(dl_data), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(dl_valid == 1'b0, "R1 valid in reset", int'(dl_valid), 0);
    rst_n = 1'b1;
    idle(2);
    check(dl_valid == 1'b0, "R1 valid after reset", int'(dl_valid), 0);

    // R2: configured but never synced
    set_cfg(2'b00, 5'd0, 8'hFF);
    run_bits(300, 0, -1, 0, 0, 0);
    drain("R2 no output before sync", 0);

    // R3 R4 R5: all frames, slot 3, full mask, two frames
    set_cfg(2'b00, 5'd3, 8'hFF);
    run_bits(512, 1, -1, 0, 0, 0);
    drain("R3/R4 all frames slot 3", 16);

    // R6 odd only, slot 31, first and last bit (R5 order)
    set_cfg(2'b01, 5'd31, 8'h81);
    run_bits(1024, 1, -1, 0, 0, 0);
    drain("R6 odd frames", 4);

    // R6 even only, slot 0, bits 1 and 3
    set_cfg(2'b10, 5'd0, 8'h0A);
    run_bits(512, 1, -1, 0, 0, 0);
    drain("R6 even frames", 2);

    // R6 unused code
    set_cfg(2'b11, 5'd2, 8'hFF);
    run_bits(512, 1, -1, 0, 0, 0);
    drain("R6 unused code", 0);

    // R7 zero mask
    set_cfg(2'b00, 5'd2, 8'h00);
    run_bits(512, 1, -1, 0, 0, 0);
    drain("R7 zero mask", 0);

    // R9: mid-frame change to zero mask applies from next frame only
    set_cfg(2'b00, 5'd5, 8'hFF);
    run_bits(512, 1, 20, 2'b00, 5'd5, 8'h00);
    drain("R9 mid-frame change held", 8);

    // R9: change slot mid-frame after tapped slot, new slot used next frame
    set_cfg(2'b00, 5'd1, 8'h0F);
    run_bits(512, 1, 100, 2'b00, 5'd20, 8'hF0);
    drain("R9 new slot next frame", 8);

    // R10: resync in mid-frame restarts position and parity
    set_cfg(2'b10, 5'd4, 8'h3C);
    run_bits(100, 1, -1, 0, 0, 0);
    set_cfg(2'b10, 5'd4, 8'hC3);
    run_bits(512, 1, -1, 0, 0, 0);
    drain("R10 resync", 4 + 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule